// File: doc/BRIEF.md
# Reference Clock Qualifier and Selector

This block watches several reference clock inputs, all sampled by one stable system clock, and decides which of them a downstream timing loop should follow. Each input is judged on two counts. First, it must keep toggling: the system clock is split into short activity windows, and an input with no rising edge in a window is charged against a per-input leaky bucket. Second, its rate must be close to nominal: rising edges are counted over a long gate and the count is compared with the count a perfect input would give.

An input that fails either test is marked unserviceable and drops out of the ranking. It comes back on its own once its measurements are good again. Software sets a 4-bit rank for each input, a bucket threshold, two offset limits that form a hysteresis band, and a switch that turns off rate-based rejection when a wider tracking range is wanted. The block reports the chosen input's index, a flag for the case where no input qualifies, per-input health, and each input's signed offset.

Top module: `refclk_qual_sel`

## Requirements
- R1: At the end of every activity window (ACT_WIN system cycles), an input with no rising edge in that window has LEAK_ADD added to its bucket (saturating), and an input with at least one edge has its bucket lowered by one if not zero. The input loses activity qualification when the bucket reaches the threshold (register address 1, reset 9) and regains it only when the bucket is back at zero.
- R2: With default settings, one dropout that leaves no more than two consecutive windows without edges does not clear the input's health bit and does not move the selection.
- R3: A long dropout, or several short dropouts close together, clears the input's health bit and moves the selection to the next-best healthy input.
- R4: Every GATE_LEN system cycles each input's offset output is loaded with (rising edges counted in that gate) minus EXPECT, as a 19-bit two's-complement value at bits [19*i+18:19*i] of `ofs_flat`. It holds its value between gates.
- R5: Rate qualification uses hysteresis. An input whose offset magnitude exceeds the reject limit (address 2, reset 32) fails. An input whose magnitude is at or below the accept limit (address 3, reset 16) passes. Between the two, the previous verdict stands.
- R6: Bit 0 of address 0 (reset 1) enables rate rejection. When it is 0, an active input is healthy whatever its offset.
- R7: Address 4+i holds the 4-bit rank of input i (reset i+1). Rank 0 takes the input out of selection. Among healthy inputs with nonzero rank, the lowest rank wins, and a tie goes to the lower index.
- R8: A rejected input returns to health and to the ranking with no software action once its bucket has drained and a gate has met the accept limit.
- R9: When no input is healthy with a nonzero rank, `no_valid` is 1 and `sel_idx` keeps its last value.
- R10: After reset, `sel_idx` is 0, `no_valid` is 1, every health bit is 0 and every offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the stable timebase |
| rst | input | 1 | Synchronous reset, active high |
| ref_clk | input | N_REF | Reference clock inputs |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration register address |
| cfg_wdata | input | DW | Configuration write data |
| sel_idx | output | SEL_W | Index of the selected input |
| no_valid | output | 1 | No input qualifies for selection |
| svc | output | N_REF | Per-input health (serviceable) bits |
| ofs_flat | output | 19*N_REF | Packed signed offsets, 19 bits per input |

## Verification
The gate length is a whole number of activity windows, so the end of a gate and the end of an activity window fall on the same cycle. At that cycle an input's rate verdict and its bucket verdict are both updated, and the health bit and the selector act on both at once. The bench provokes this by stopping an input for several hundred cycles, so that one gate sees both a missing window and a large negative offset. It checks that the input drops out and that the selection moves. It then checks that the input comes back only after both its bucket has drained and a clean gate has been seen, by sampling the selection and the offset outputs after each gate.

// File: rtl/refq_pkg.sv
package refq_pkg;

    localparam int OFS_W   = 19;
    localparam int PRIO_W  = 4;
    localparam int OFS_MAX = (1 << (OFS_W - 1)) - 1;
    localparam int OFS_MIN = -(1 << (OFS_W - 1));

    // configuration register addresses
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_THR  = 1;
    localparam int ADDR_REJ  = 2;
    localparam int ADDR_ACC  = 3;
    localparam int ADDR_RANK = 4;

    typedef logic signed [OFS_W-1:0] ofs_t;
    typedef logic [PRIO_W-1:0]       rank_t;

    typedef struct packed {
        logic        rate_chk_en;
        logic [15:0] rej_lim;
        logic [15:0] acc_lim;
    } rate_cfg_t;

    function automatic ofs_t sat_ofs(input int v);
        if (v > OFS_MAX) return ofs_t'(OFS_MAX);
        if (v < OFS_MIN) return ofs_t'(OFS_MIN);
        return ofs_t'(v);
    endfunction

    function automatic int ofs_mag(input ofs_t v);
        int x;
        x = int'(v);
        return (x < 0) ? -x : x;
    endfunction

endpackage

// File: rtl/refq_cfg.sv
module refq_cfg
    import refq_pkg::*;
#(
    parameter int N_REF   = 4,
    parameter int AW      = 4,
    parameter int DW      = 16,
    parameter int BKT_W   = 6,
    parameter int THR_RST = 9,
    parameter int REJ_RST = 32,
    parameter int ACC_RST = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    output rate_cfg_t             rate_cfg,
    output logic [BKT_W-1:0]      bkt_thr,
    output rank_t [N_REF-1:0]     rank
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_cfg.rate_chk_en <= 1'b1;
            rate_cfg.rej_lim     <= 16'(REJ_RST);
            rate_cfg.acc_lim     <= 16'(ACC_RST);
            bkt_thr              <= BKT_W'(THR_RST);
            for (int i = 0; i < N_REF; i++) rank[i] <= rank_t'(i + 1);
        end else if (we) begin
            if (addr == AW'(ADDR_CTRL)) rate_cfg.rate_chk_en <= wdata[0];
            if (addr == AW'(ADDR_THR))  bkt_thr              <= wdata[BKT_W-1:0];
            if (addr == AW'(ADDR_REJ))  rate_cfg.rej_lim     <= wdata[15:0];
            if (addr == AW'(ADDR_ACC))  rate_cfg.acc_lim     <= wdata[15:0];
            for (int i = 0; i < N_REF; i++)
                if (addr == AW'(ADDR_RANK + i)) rank[i] <= wdata[PRIO_W-1:0];
        end
    end

endmodule

// File: rtl/refq_monitor.sv
module refq_monitor
    import refq_pkg::*;
#(
    parameter int GATE_LEN = 1024,
    parameter int EXPECT   = 128,
    parameter int LEAK_ADD = 4,
    parameter int BKT_W    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             win_tick,
    input  logic             gate_tick,
    input  rate_cfg_t        rate_cfg,
    input  logic [BKT_W-1:0] bkt_thr,
    output ofs_t             ofs,
    output logic             svc
);

    localparam int CNT_W   = $clog2(GATE_LEN + 2);
    localparam int BKT_MAX = (1 << BKT_W) - 1;

    logic [2:0]       sync_q;
    logic             rise;
    logic             seen_q;
    logic             hit;
    logic [BKT_W-1:0] bkt_q;
    logic [BKT_W-1:0] bkt_nxt;
    logic             act_bad_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rate_ok_q;
    ofs_t             ofs_nxt;
    int               mag_nxt;

    assign rise = sync_q[1] & ~sync_q[2];
    assign hit  = seen_q | rise;

    always_comb begin
        if (!hit) begin
            if (int'(bkt_q) + LEAK_ADD > BKT_MAX) bkt_nxt = BKT_W'(BKT_MAX);
            else                                  bkt_nxt = BKT_W'(int'(bkt_q) + LEAK_ADD);
        end else if (bkt_q != '0) begin
            bkt_nxt = bkt_q - 1'b1;
        end else begin
            bkt_nxt = '0;
        end
        ofs_nxt = sat_ofs(int'(cnt_q) + (rise ? 1 : 0) - EXPECT);
        mag_nxt = ofs_mag(ofs_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= '0;
            seen_q    <= 1'b0;
            bkt_q     <= '0;
            act_bad_q <= 1'b0;
            cnt_q     <= '0;
            rate_ok_q <= 1'b0;
            ofs       <= '0;
        end else begin
            sync_q <= {sync_q[1:0], ref_in};
            // activity: leaky bucket per window
            if (win_tick) begin
                seen_q <= 1'b0;
                bkt_q  <= bkt_nxt;
                if (bkt_nxt >= bkt_thr)  act_bad_q <= 1'b1;
                else if (bkt_nxt == '0)  act_bad_q <= 1'b0;
            end else if (rise) begin
                seen_q <= 1'b1;
            end
            // rate: edge count over a gate, with hysteresis
            if (gate_tick) begin
                cnt_q <= '0;
                ofs   <= ofs_nxt;
                if (mag_nxt > int'(rate_cfg.rej_lim))       rate_ok_q <= 1'b0;
                else if (mag_nxt <= int'(rate_cfg.acc_lim)) rate_ok_q <= 1'b1;
            end else if (rise) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign svc = ~act_bad_q & (rate_ok_q | ~rate_cfg.rate_chk_en);

endmodule

// File: rtl/refq_select.sv
module refq_select
    import refq_pkg::*;
#(
    parameter int N_REF = 4,
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_REF-1:0]  svc,
    input  rank_t [N_REF-1:0] rank,
    output logic [SEL_W-1:0]  sel_idx,
    output logic              no_valid
);

    logic             found;
    logic [SEL_W-1:0] best;
    rank_t            best_rank;

    always_comb begin
        found     = 1'b0;
        best      = '0;
        best_rank = '1;
        for (int i = 0; i < N_REF; i++) begin
            // strict compare: ties keep the lower index
            if (svc[i] && rank[i] != '0 && (!found || rank[i] < best_rank)) begin
                found     = 1'b1;
                best      = SEL_W'(i);
                best_rank = rank[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_idx  <= '0;
            no_valid <= 1'b1;
        end else begin
            no_valid <= ~found;
            if (found && best != sel_idx) sel_idx <= best;
        end
    end

endmodule

// File: rtl/refclk_qual_sel.sv
module refclk_qual_sel
    import refq_pkg::*;
#(
    parameter int N_REF    = 4,
    parameter int ACT_WIN  = 16,
    parameter int GATE_LEN = 1024,
    parameter int EXPECT   = 128,
    parameter int LEAK_ADD = 4,
    parameter int BKT_W    = 6,
    parameter int AW       = 4,
    parameter int DW       = 16,
    localparam int SEL_W   = (N_REF > 1) ? $clog2(N_REF) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_REF-1:0]       ref_clk,
    input  logic                   cfg_we,
    input  logic [AW-1:0]          cfg_addr,
    input  logic [DW-1:0]          cfg_wdata,
    output logic [SEL_W-1:0]       sel_idx,
    output logic                   no_valid,
    output logic [N_REF-1:0]       svc,
    output logic [OFS_W*N_REF-1:0] ofs_flat
);

    localparam int WIN_CW  = $clog2(ACT_WIN);
    localparam int GATE_CW = $clog2(GATE_LEN);

    logic [WIN_CW-1:0]  win_cnt_q;
    logic [GATE_CW-1:0] gate_cnt_q;
    logic               win_tick;
    logic               gate_tick;
    rate_cfg_t          rate_cfg;
    logic [BKT_W-1:0]   bkt_thr;
    rank_t [N_REF-1:0]  rank;
    ofs_t               ofs_w [N_REF];

    assign win_tick  = (win_cnt_q == WIN_CW'(ACT_WIN - 1));
    assign gate_tick = (gate_cnt_q == GATE_CW'(GATE_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt_q  <= '0;
            gate_cnt_q <= '0;
        end else begin
            win_cnt_q  <= win_tick  ? '0 : win_cnt_q + 1'b1;
            gate_cnt_q <= gate_tick ? '0 : gate_cnt_q + 1'b1;
        end
    end

    refq_cfg #(
        .N_REF(N_REF), .AW(AW), .DW(DW), .BKT_W(BKT_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rate_cfg(rate_cfg), .bkt_thr(bkt_thr), .rank(rank)
    );

    for (genvar i = 0; i < N_REF; i++) begin : g_mon
        refq_monitor #(
            .GATE_LEN(GATE_LEN), .EXPECT(EXPECT), .LEAK_ADD(LEAK_ADD), .BKT_W(BKT_W)
        ) u_mon (
            .clk(clk), .rst(rst), .ref_in(ref_clk[i]),
            .win_tick(win_tick), .gate_tick(gate_tick),
            .rate_cfg(rate_cfg), .bkt_thr(bkt_thr),
            .ofs(ofs_w[i]), .svc(svc[i])
        );
        assign ofs_flat[OFS_W*i +: OFS_W] = ofs_w[i];
    end

    refq_select #(.N_REF(N_REF), .SEL_W(SEL_W)) u_sel (
        .clk(clk), .rst(rst), .svc(svc), .rank(rank),
        .sel_idx(sel_idx), .no_valid(no_valid)
    );

endmodule

// File: rtl/refq_chk.sv
module refq_chk #(
    parameter int N_REF = 4,
    parameter int SEL_W = 2,
    parameter int OFW   = 76
) (
    input logic             clk,
    input logic             rst,
    input logic [N_REF-1:0] svc,
    input logic [SEL_W-1:0] sel_idx,
    input logic             no_valid,
    input logic [OFW-1:0]   ofs_flat,
    input logic             gate_tick
);

    logic [N_REF-1:0] svc_d;

    always_ff @(posedge clk) begin
        if (rst) svc_d <= '0;
        else     svc_d <= svc;
    end

    // R7: a valid selection names an input that was healthy when chosen
    p_sel_healthy_r7: assert property (@(posedge clk) disable iff (rst)
        !no_valid |-> svc_d[sel_idx]);

    // R9: while nothing qualifies the index is held
    p_hold_sel_r9: assert property (@(posedge clk) disable iff (rst)
        (no_valid && $past(no_valid)) |-> $stable(sel_idx));

    // R3: the index only moves onto a qualifying input
    p_move_valid_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_idx) |-> !no_valid);

    // R4: offsets change only right after a gate closes
    p_ofs_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(gate_tick) |-> $stable(ofs_flat));

endmodule

bind refclk_qual_sel refq_chk #(
    .N_REF(N_REF), .SEL_W(SEL_W), .OFW(refq_pkg::OFS_W * N_REF)
) u_chk (
    .clk(clk), .rst(rst), .svc(svc), .sel_idx(sel_idx),
    .no_valid(no_valid), .ofs_flat(ofs_flat), .gate_tick(gate_tick)
);

// File: tb/tb_refclk_qual_sel.sv
module tb_refclk_qual_sel;

    localparam int N    = 4;
    localparam int GATE = 1024;
    localparam int SETTLE = 3 * GATE + 1200;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  ref_clk = '0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [15:0]   cfg_wdata = '0;
    logic [1:0]    sel_idx;
    logic          no_valid;
    logic [N-1:0]  svc;
    logic [19*N-1:0] ofs_flat;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int hp [N]   = '{4, 4, 4, 4};
    bit run [N]  = '{1, 1, 1, 1};
    int pc [N]   = '{0, 0, 0, 0};

    always #4 clk = ~clk;

    refclk_qual_sel dut (
        .clk(clk), .rst(rst), .ref_clk(ref_clk), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .sel_idx(sel_idx),
        .no_valid(no_valid), .svc(svc), .ofs_flat(ofs_flat)
    );

    // reference generators, driven away from the active edge
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (run[i] && hp[i] != 0) begin
                pc[i] = pc[i] + 1;
                if (pc[i] >= hp[i]) begin
                    pc[i] = 0;
                    ref_clk[i] <= ~ref_clk[i];
                end
            end
        end
    end

    // vector: hp3..hp0, rank3..rank0, expected sel, expected no_valid
    localparam logic [34:0] VEC [8] = '{
        {4'd4, 4'd4, 4'd4, 4'd4, 4'd4, 4'd3, 4'd2, 4'd1, 2'd0, 1'b0},
        {4'd4, 4'd4, 4'd4, 4'd4, 4'd4, 4'd2, 4'd1, 4'd3, 2'd1, 1'b0},
        {4'd4, 4'd4, 4'd4, 4'd4, 4'd1, 4'd1, 4'd2, 4'd2, 2'd2, 1'b0},
        {4'd4, 4'd6, 4'd4, 4'd4, 4'd1, 4'd1, 4'd2, 4'd2, 2'd3, 1'b0},
        {4'd4, 4'd6, 4'd4, 4'd4, 4'd0, 4'd0, 4'd0, 4'd0, 2'd3, 1'b1},
        {4'd4, 4'd4, 4'd4, 4'd4, 4'd0, 4'd1, 4'd5, 4'd0, 2'd2, 1'b0},
        {4'd4, 4'd4, 4'd4, 4'd0, 4'd4, 4'd3, 4'd2, 4'd1, 2'd1, 1'b0},
        {4'd4, 4'd4, 4'd4, 4'd4, 4'd4, 4'd3, 4'd2, 4'd1, 2'd0, 1'b0}
    };

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input longint act, input longint lo, input longint hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_ref(input int i, input int n);
        run[i] = 1'b0;
        wait_cyc(n);
        run[i] = 1'b1;
    endtask

    function automatic int ofs_of(input int i);
        logic signed [18:0] v;
        v = ofs_flat[19*i +: 19];
        return int'(v);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(20);
        // R10: reset state
        check("R10 sel_idx", sel_idx, 0);
        check("R10 no_valid", no_valid, 1);
        check("R10 svc", svc, 0);
        check("R10 ofs", ofs_flat, 0);

        // table walk: R7 ranking, R5 rejection, R9 hold, R8 restore, R3 stop
        for (int v = 0; v < 8; v++) begin
            for (int i = 0; i < N; i++) begin
                hp[i]  = int'(VEC[v][19 + 4*i +: 4]);
                run[i] = (hp[i] != 0);
            end
            for (int i = 0; i < N; i++) wr(4 + i, int'(VEC[v][3 + 4*i +: 4]));
            wait_cyc(SETTLE);
            check($sformatf("R7 vector %0d sel_idx", v), sel_idx, VEC[v][2:1]);
            check($sformatf("R9 vector %0d no_valid", v), no_valid, VEC[v][0]);
            if (hp[1] == 4) check($sformatf("R4 vector %0d ofs1", v), ofs_of(1), 0);
        end

        // R4: offset of a slow input (period 12 over 1024 cycles)
        hp[2] = 6;
        wait_cyc(3 * GATE);
        check_rng("R4 ofs2 slow", ofs_of(2), -43, -42);
        check("R5 svc2 rejected", svc[2], 0);
        // R5 hysteresis: between limits the verdict holds
        wr(2, 100); wr(3, 10);
        wait_cyc(2 * GATE);
        check("R5 held rejected", svc[2], 0);
        wr(3, 70);
        wait_cyc(2 * GATE);
        check("R5 accepted", svc[2], 1);
        wr(3, 10);
        wait_cyc(2 * GATE);
        check("R5 held accepted", svc[2], 1);
        wr(2, 40);
        wait_cyc(2 * GATE);
        check("R5 over reject", svc[2], 0);
        wr(2, 32); wr(3, 16);

        // R6: disable rate rejection, slow input becomes usable
        wr(0, 0);
        wr(4, 4); wr(5, 3); wr(6, 1); wr(7, 2);
        wait_cyc(2 * GATE);
        check("R6 svc2 with check off", svc[2], 1);
        check("R6 sel_idx", sel_idx, 2);
        wr(0, 1);
        wait_cyc(2 * GATE);
        check("R6 svc2 with check on", svc[2], 0);
        hp[2] = 4;
        wr(4, 1); wr(5, 2); wr(6, 3); wr(7, 4);
        wait_cyc(SETTLE);
        check("R8 back to input 0", sel_idx, 0);

        // R2: one short dropout is tolerated
        stop_ref(0, 24);
        wait_cyc(64);
        check("R2 svc0 after short dropout", svc[0], 1);
        check("R2 sel_idx", sel_idx, 0);
        wait_cyc(SETTLE);

        // R3: repeated short dropouts force a switch
        for (int k = 0; k < 4; k++) begin
            stop_ref(0, 40);
            wait_cyc(16);
        end
        wait_cyc(16);
        check("R3 svc0 after repeated dropouts", svc[0], 0);
        check("R3 sel_idx after repeated dropouts", sel_idx, 1);
        wait_cyc(SETTLE);
        check("R8 restored after repeated dropouts", sel_idx, 0);

        // R3: long interruption, window and gate verdicts coincide
        stop_ref(0, 300);
        wait_cyc(16);
        check("R3 svc0 after long stop", svc[0], 0);
        check("R3 sel_idx after long stop", sel_idx, 1);
        wait_cyc(SETTLE);
        check("R8 svc0 restored", svc[0], 1);
        check("R8 sel_idx restored", sel_idx, 0);

        // R1: lower threshold makes one dropout fatal
        wr(1, 4);
        stop_ref(0, 40);
        wait_cyc(16);
        check("R1 svc0 with threshold 4", svc[0], 0);
        wr(1, 9);
        wait_cyc(SETTLE);
        check("R1 svc0 after drain", svc[0], 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule